// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a memory-mapped up-counter that raises a periodic level interrupt. A tick-enable input, pulsed once per counting period (500 ns in the intended system), advances a count field. The field sits in the upper bits of a 32-bit word, with the low 9 bits always zero. Software programs a limit. When the count reaches that limit the block sets a sticky flag in bit 31 of the count word, raises its interrupt, and starts counting again from zero. The interrupt therefore repeats every `limit >> 9` ticks.

Software services the interrupt by reading the limit word back. That read returns the limit and also clears both the flag and the interrupt line. A second limit address lets software change the period without disturbing the running count. A limit of zero makes the counter run freely through its whole range and wrap, and it never signals a match. The bus fabric and the generation of the tick are outside this block. Accesses are single full-word transfers presented for one clock cycle. Read data is combinational from the current state, and any side effect takes place at the clock edge that ends the access.

Top module: `ivt_timer`

## Requirements
- R1: After reset the limit and count are zero, the sticky flag is clear and `irq_o` is low, so reads of word 0x0 and word 0x4 both return 0.
- R2: Each cycle with `tick_i` high adds one unit of bit 9 to the count field. With default parameters that field is bits 30:9; in general it is bits `9+CNT_W-1:9`. Bits 8:0 of every read are zero.
- R3: A write to byte offset 0x0 keeps only the count-field bits of the write data as the new limit. It sets the count to zero and drives `irq_o` low, and it leaves the sticky flag unchanged. A read of 0x0 returns the limit in the count-field position, with every other bit zero.
- R4: A write to byte offset 0x8 stores the masked limit in the same way but does not alter the count, which keeps advancing toward the new limit.
- R5: With a nonzero limit field L, the tick that would bring the count to L instead sets the count to 0. The same tick sets bit 31 of the 0x4 word and drives `irq_o` high. After k ticks from a reset of the count, word 0x4 reads `((k mod L) << 9) | (k >= L ? 1<<31 : 0)`.
- R6: With a limit of zero the count wraps from its all-ones value (0x7FFFFE00 with default parameters) to zero. It never sets the sticky flag and never raises `irq_o`.
- R7: A read of byte offset 0x0 clears the sticky flag and drives `irq_o` low.
- R8: Any other address, including offset 0xC and any address that is not word-aligned, reads as zero, and a write to it changes no state.
- R9: If a match falls in the same cycle as a read of 0x0, the match wins: the flag and `irq_o` end up set. If a tick falls in the same cycle as a write to 0x0, the write wins and the count ends at zero.
- R10: In cycles with `tick_i` low the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe, one cycle per counting period |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current access (combinational) |
| irq_o | output | 1 | Level interrupt, high from a match until acknowledged or reloaded |

## Verification
Two pairs of functions can collide in one cycle. A limit match can coincide with the acknowledging read of the limit word, and a count tick can coincide with a reloading limit write. The bench arranges both collisions by counting the count up to one tick short of the limit. It then issues the read, or the write, in the same cycle as the final tick. It judges the outcome by the interrupt line and the count word read in the following cycles: after the first collision the flag and interrupt must remain set, and after the second the count must be zero with the interrupt low.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    // Word selector taken from byte address bits 3:2.
    typedef enum logic [1:0] {
        SEL_LIMIT      = 2'd0,
        SEL_COUNT      = 2'd1,
        SEL_LIMIT_KEEP = 2'd2,
        SEL_SPARE      = 2'd3
    } reg_sel_e;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned FLAG_BIT = 31;
endpackage

// File: rtl/ivt_regif.sv
module ivt_regif
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 22,
    parameter int unsigned LSB    = 9
) (
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [CNT_W-1:0]  limit_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              reached_i,
    output logic              wr_rst_o,
    output logic              wr_keep_o,
    output logic              rd_ack_o,
    output logic [CNT_W-1:0]  wlimit_o,
    output logic [31:0]       rdata_o
);
    localparam int unsigned HI = LSB + CNT_W - 1;

    logic     upper_zero;
    logic     valid_addr;
    reg_sel_e sel;

    // Address bits above the 16-byte window must be zero for a hit.
    generate
        if (ADDR_W > 4) begin : g_upper
            assign upper_zero = (addr_i[ADDR_W-1:4] == '0);
        end else begin : g_noupper
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        sel        = reg_sel_e'(addr_i[3:2]);
        valid_addr = req_i && upper_zero && (addr_i[1:0] == 2'b00);
        wr_rst_o   = valid_addr && we_i  && (sel == SEL_LIMIT);
        wr_keep_o  = valid_addr && we_i  && (sel == SEL_LIMIT_KEEP);
        rd_ack_o   = valid_addr && !we_i && (sel == SEL_LIMIT);
        wlimit_o   = wdata_i[HI:LSB];
        rdata_o    = '0;
        if (valid_addr && !we_i) begin
            unique case (sel)
                SEL_LIMIT: rdata_o = 32'(limit_i) << LSB;
                SEL_COUNT: begin
                    rdata_o           = 32'(count_i) << LSB;
                    rdata_o[FLAG_BIT] = reached_i;
                end
                default:   rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
    parameter int unsigned CNT_W = 22
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] next_o,
    output logic             match_o
);
    logic [CNT_W-1:0] inc;

    always_comb begin
        inc     = count_i + 1'b1;
        match_o = (limit_i != '0) && (inc == limit_i);
        next_o  = match_o ? '0 : inc;
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 22,
    parameter int unsigned LSB    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] count;
        logic             reached;
        logic             irq;
    } state_t;

    state_t state_d, state_q;

    logic             wr_rst, wr_keep, rd_ack, match;
    logic [CNT_W-1:0] wlimit, cnt_next;

    ivt_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LSB(LSB)) u_regif (
        .req_i     (req_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .limit_i   (state_q.limit),
        .count_i   (state_q.count),
        .reached_i (state_q.reached),
        .wr_rst_o  (wr_rst),
        .wr_keep_o (wr_keep),
        .rd_ack_o  (rd_ack),
        .wlimit_o  (wlimit),
        .rdata_o   (rdata_o)
    );

    ivt_count #(.CNT_W(CNT_W)) u_count (
        .count_i (state_q.count),
        .limit_i (state_q.limit),
        .next_o  (cnt_next),
        .match_o (match)
    );

    // Priority: the acknowledge clears first, so a same-cycle match re-sets
    // the flags; a reloading write overrides the tick.
    always_comb begin
        state_d = state_q;
        if (rd_ack) begin
            state_d.reached = 1'b0;
            state_d.irq     = 1'b0;
        end
        if (wr_rst) begin
            state_d.limit = wlimit;
            state_d.count = '0;
            state_d.irq   = 1'b0;
        end else if (tick_i) begin
            state_d.count = cnt_next;
            if (match) begin
                state_d.reached = 1'b1;
                state_d.irq     = 1'b1;
            end
        end
        if (wr_keep) begin
            state_d.limit = wlimit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.irq;

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> (state_q.count == '0) && !irq_o);

    assert_keep_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_keep && !tick_i |=> $stable(state_q.count));

    assert_irq_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> state_q.reached);

    assert_no_freerun_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick_i) && ($past(state_q.limit) != '0));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !(tick_i && match) |=> !irq_o && !state_q.reached);

    assert_match_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && match && !wr_rst |=> irq_o && state_q.reached && (state_q.count == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !wr_rst |=> $stable(state_q.count));

    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !we_i |-> (rdata_o[LSB-1:0] == '0));
endmodule

// File: tb/tb_ivt_timer.sv
`timescale 1ns/1ps
module tb_ivt_timer;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned CNT_W  = 6;
    localparam int unsigned LSB    = 9;
    localparam int unsigned SPAN   = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic              req_i = 1'b0;
    logic              we_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic              irq_o;

    int vecs = 0;
    int errs = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    ivt_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LSB(LSB)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One cycle: drive after an edge, sample read data mid-cycle, end after next edge.
    task automatic cyc(input logic tk, input logic v, input logic w,
                       input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        tick_i = tk; req_i = v; we_i = w; addr_i = a; wdata_i = d;
        #1;
        r = rdata_o;
        @(posedge clk);
        #1;
        tick_i = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    endtask

    task automatic ticks(input int n);
        logic [31:0] r;
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, '0, '0, r);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [31:0] r;
        cyc(1'b0, 1'b1, 1'b1, a, d, r);
    endtask

    task automatic rdw(input logic [ADDR_W-1:0] a, output logic [31:0] r);
        cyc(1'b0, 1'b1, 1'b0, a, '0, r);
    endtask

    function automatic logic [31:0] cnt_word(input int k, input int lim);
        int c;
        c = (lim == 0) ? (k % SPAN) : (k % lim);
        return (32'(c) << LSB) | ((lim != 0 && k >= lim) ? 32'h8000_0000 : 32'h0);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rdw(4'h0, rd); chk("R1 limit", rd, 32'h0);
        rdw(4'h4, rd); chk("R1 count", rd, 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);

        // R10 no tick, no count
        repeat (5) rdw(4'h4, rd);
        chk("R10 hold", rd, 32'h0);

        // R6 free-run: full wrap, never flags
        wr(4'h0, 32'h0000_01FF);
        for (int k = 1; k <= SPAN + 2; k++) begin
            ticks(1);
            rdw(4'h4, rd);
            chk("R6 freerun count", rd, cnt_word(k, 0));
            chk("R6 freerun irq", 32'(irq_o), 32'h0);
        end

        // R2 R3 R5 R7 sweep over every nonzero limit
        for (int lim = 1; lim < SPAN; lim++) begin
            wr(4'h0, (32'(lim) << LSB) | 32'h8000_01FF | (32'h7FFF_FFFF & ~((32'(SPAN) - 1) << LSB) & ~32'h1FF));
            rdw(4'h0, rd); chk("R3 limit readback", rd, 32'(lim) << LSB);
            chk("R3 irq low", 32'(irq_o), 32'h0);
            for (int k = 1; k <= 2 * lim + 1; k++) begin
                ticks(1);
                rdw(4'h4, rd);
                chk("R5 R2 count word", rd, cnt_word(k, lim));
                chk("R5 irq", 32'(irq_o), (k >= lim) ? 32'h1 : 32'h0);
            end
            rdw(4'h0, rd);
            chk("R7 ack irq", 32'(irq_o), 32'h0);
            rdw(4'h4, rd);
            chk("R7 flag cleared", rd[31:0] & 32'h8000_0000, 32'h0);
        end

        // R9 match coincides with acknowledge: match wins
        wr(4'h0, 32'(4) << LSB);
        ticks(3);
        cyc(1'b1, 1'b1, 1'b0, 4'h0, '0, rd);
        chk("R9 read during match", rd, 32'(4) << LSB);
        chk("R9 irq after collision", 32'(irq_o), 32'h1);
        rdw(4'h4, rd); chk("R9 count word after collision", rd, 32'h8000_0000);

        // R9 tick coincides with reload: reload wins; R3 flag kept
        ticks(2);
        cyc(1'b1, 1'b1, 1'b1, 4'h0, 32'(4) << LSB, rd);
        chk("R9 reload irq", 32'(irq_o), 32'h0);
        rdw(4'h4, rd); chk("R9 R3 reload count", rd, 32'h8000_0000);
        rdw(4'h0, rd);

        // R4 limit change without count reset
        wr(4'h0, 32'(10) << LSB);
        ticks(3);
        wr(4'h8, 32'(20) << LSB);
        rdw(4'h4, rd); chk("R4 count kept", rd, 32'(3) << LSB);
        rdw(4'h0, rd); chk("R4 new limit", rd, 32'(20) << LSB);
        ticks(16);
        chk("R4 no early irq", 32'(irq_o), 32'h0);
        rdw(4'h4, rd); chk("R4 count", rd, 32'(19) << LSB);
        ticks(1);
        chk("R4 irq at new limit", 32'(irq_o), 32'h1);
        rdw(4'h0, rd);

        // R8 undefined offsets
        wr(4'h0, 32'(7) << LSB);
        ticks(2);
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h1, 32'hFFFF_FFFF);
        wr(4'h2, 32'h0000_0000);
        rdw(4'hC, rd); chk("R8 read 0xC", rd, 32'h0);
        rdw(4'h5, rd); chk("R8 read misaligned", rd, 32'h0);
        rdw(4'h0, rd); chk("R8 limit untouched", rd, 32'(7) << LSB);
        rdw(4'h4, rd); chk("R8 count untouched", rd, 32'(2) << LSB);
        chk("R8 irq untouched", 32'(irq_o), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule